// File: doc/BRIEF.md
# Address-Event Spike Serialiser with Binary-Tree Arbitration

This block gathers spike requests from N neurons and sends them, one at a time, over a single shared event bus. Each event carries only the binary index of the neuron that fired, so the bus is log2(N) wires wide no matter how many neurons share it. When several neurons fire together, a tree of two-input arbiter cells picks one winner. The tree is log2(N) levels deep, and each cell takes turns between its two inputs when both are asking.

A neuron raises its request line and keeps it high until it sees its acknowledge pulse. The acknowledge comes in the cycle where the event leaves the bus, which is the cycle where valid and ready are both high. A receive-side decoder in the same block turns each accepted address back into a one-cycle one-hot strobe on the matching target line. A stalled bus holds its event and loses nothing, and at most one event leaves per clock.

Top module: `aer_spike_link`

## Requirements
- R1: While `bus_valid` is high, `bus_addr` is the index of a neuron whose `spk_req` bit is high (bit k of `spk_req` belongs to neuron k, and the address is k in plain binary).
- R2: `spk_ack` is all zeros except in a cycle where `bus_valid` and `bus_ready` are both high. In that cycle it holds exactly one set bit, at position `bus_addr`.
- R3: While `bus_valid` is high and `bus_ready` is low, `bus_valid` stays high and `bus_addr` stays the same in the next cycle.
- R4: Each raised request is acknowledged exactly once. No neuron is acknowledged while its request is low.
- R5: Every request that is held until acknowledged is acknowledged eventually, provided `bus_ready` is high often enough.
- R6: Arbitration takes turns. A requesting neuron waits for no more than 2·N events of other neurons before it is served.
- R7: In the cycle after an accepted event, `dec_strobe` is one-hot, with its bit at the accepted address. In every other cycle `dec_strobe` is all zeros.
- R8: While reset is high, and in the first cycle after it, `bus_valid`, `spk_ack` and `dec_strobe` are zero.
- R9: If no request was high in a cycle, `bus_valid` is low in the next cycle.
- R10: When an event is accepted and some other neuron's request is high in that same cycle, `bus_valid` is high in the next cycle. This gives back-to-back events at one per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| spk_req | input | N | Per-neuron spike request, held until acknowledged |
| spk_ack | output | N | Per-neuron acknowledge, one cycle, on acceptance |
| bus_addr | output | log2(N) | Address of the neuron whose event is on the bus |
| bus_valid | output | 1 | An event is present on the bus |
| bus_ready | input | 1 | The receiver takes the event this cycle |
| dec_strobe | output | N | Decoded one-hot target strobe, one cycle after acceptance |

## Verification
A wrong turn bit in a tree cell shows up at the ports as a neuron whose wait, counted in other neurons' events, goes past the 2·N bound within a few dozen events of steady contention. A wrong held address or held-neuron mask shows up in the same cycle: either `bus_addr` points at an idle neuron, or a neuron is acknowledged twice. A fault in the output register or the decoder shows up one cycle later, as an event that changes during a stall, a missing back-to-back event, or a strobe on the wrong line.

// File: rtl/aer_pkg.sv
package aer_pkg;

    // Turn state of one two-input arbiter cell
    typedef enum logic {
        FAV_LO = 1'b0,
        FAV_HI = 1'b1
    } favor_e;

    // Heap index of the leaf node that holds neuron k
    function automatic int leaf_node(input int n, input int k);
        return n + k;
    endfunction

    // Width of an index for n entries, at least one bit
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/aer_arb_cell.sv
module aer_arb_cell
    import aer_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic commit,
    input  logic req_lo,
    input  logic req_hi,
    input  logic gnt_in,
    output logic any,
    output logic gnt_lo,
    output logic gnt_hi
);

    favor_e fav_q;
    logic   pick_lo;

    always_comb begin
        pick_lo = req_lo & (~req_hi | (fav_q == FAV_LO));
        any     = req_lo | req_hi;
        gnt_lo  = gnt_in & pick_lo;
        gnt_hi  = gnt_in & ~pick_lo & req_hi;
    end

    // The turn bit moves only when a real contest is resolved and committed
    always_ff @(posedge clk) begin
        if (rst) begin
            fav_q <= FAV_LO;
        end else if (commit && gnt_in && req_lo && req_hi) begin
            fav_q <= pick_lo ? FAV_HI : FAV_LO;
        end
    end

endmodule

// File: rtl/aer_arb_tree.sv
module aer_arb_tree
    import aer_pkg::*;
#(
    parameter int N = 8,
    localparam int AW = idx_width(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          commit,
    input  logic [N-1:0]  cand,
    output logic          found,
    output logic [N-1:0]  win_oh,
    output logic [AW-1:0] win_addr
);

    // Heap layout: node 1 is the root, node i has children 2i and 2i+1,
    // leaves sit at N..2N-1
    logic any_n [2*N];
    logic gnt_n [2*N];

    assign any_n[0] = 1'b0;
    assign gnt_n[0] = 1'b0;
    assign gnt_n[1] = any_n[1];

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_leaf
            assign any_n[leaf_node(N, g)] = cand[g];
            assign win_oh[g]              = gnt_n[leaf_node(N, g)];
        end
        for (g = 1; g < N; g++) begin : g_node
            aer_arb_cell u_cell (
                .clk    (clk),
                .rst    (rst),
                .commit (commit),
                .req_lo (any_n[2*g]),
                .req_hi (any_n[2*g+1]),
                .gnt_in (gnt_n[g]),
                .any    (any_n[g]),
                .gnt_lo (gnt_n[2*g]),
                .gnt_hi (gnt_n[2*g+1])
            );
        end
    endgenerate

    assign found = any_n[1];

    always_comb begin
        win_addr = '0;
        for (int k = 0; k < N; k++) begin
            if (win_oh[k]) win_addr = win_addr | AW'(k);
        end
    end

endmodule

// File: rtl/aer_enc.sv
module aer_enc
    import aer_pkg::*;
#(
    parameter int N = 8,
    localparam int AW = idx_width(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  spk_req,
    output logic [N-1:0]  spk_ack,
    output logic [AW-1:0] bus_addr,
    output logic          bus_valid,
    input  logic          bus_ready,
    output logic          fire
);

    logic [N-1:0]  held_oh;
    logic [N-1:0]  cand;
    logic [N-1:0]  win_oh;
    logic [AW-1:0] win_addr;
    logic          found;
    logic          load;

    always_comb begin
        held_oh = '0;
        for (int k = 0; k < N; k++) begin
            held_oh[k] = bus_valid && (bus_addr == AW'(k));
        end
        // The neuron already on the bus stays out of the contest
        cand    = spk_req & ~held_oh;
        fire    = bus_valid & bus_ready;
        load    = ~bus_valid | bus_ready;
        spk_ack = fire ? held_oh : '0;
    end

    aer_arb_tree #(.N(N)) u_tree (
        .clk      (clk),
        .rst      (rst),
        .commit   (load),
        .cand     (cand),
        .found    (found),
        .win_oh   (win_oh),
        .win_addr (win_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_valid <= 1'b0;
            bus_addr  <= '0;
        end else if (load) begin
            bus_valid <= found;
            if (found) bus_addr <= win_addr;
        end
    end

endmodule

// File: rtl/aer_dec.sv
module aer_dec
    import aer_pkg::*;
#(
    parameter int N = 8,
    localparam int AW = idx_width(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fire,
    input  logic [AW-1:0] addr,
    output logic [N-1:0]  strobe
);

    logic [N-1:0] line_d;

    always_comb begin
        line_d = '0;
        for (int k = 0; k < N; k++) begin
            line_d[k] = fire && (addr == AW'(k));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) strobe <= '0;
        else     strobe <= line_d;
    end

endmodule

// File: rtl/aer_spike_link.sv
module aer_spike_link
    import aer_pkg::*;
#(
    parameter int N = 8,
    localparam int AW = idx_width(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  spk_req,
    output logic [N-1:0]  spk_ack,
    output logic [AW-1:0] bus_addr,
    output logic          bus_valid,
    input  logic          bus_ready,
    output logic [N-1:0]  dec_strobe
);

    logic fire;

    aer_enc #(.N(N)) u_enc (
        .clk       (clk),
        .rst       (rst),
        .spk_req   (spk_req),
        .spk_ack   (spk_ack),
        .bus_addr  (bus_addr),
        .bus_valid (bus_valid),
        .bus_ready (bus_ready),
        .fire      (fire)
    );

    aer_dec #(.N(N)) u_dec (
        .clk    (clk),
        .rst    (rst),
        .fire   (fire),
        .addr   (bus_addr),
        .strobe (dec_strobe)
    );

endmodule

// File: rtl/aer_spike_link_chk.sv
module aer_spike_link_chk
    import aer_pkg::*;
#(
    parameter int N = 8,
    localparam int AW = idx_width(N)
) (
    input logic          clk,
    input logic          rst,
    input logic [N-1:0]  spk_req,
    input logic [N-1:0]  spk_ack,
    input logic [AW-1:0] bus_addr,
    input logic          bus_valid,
    input logic          bus_ready,
    input logic [N-1:0]  dec_strobe
);

    // R1
    addr_live_chk: assert property (@(posedge clk) disable iff (rst)
        bus_valid |-> spk_req[bus_addr]);

    // R2
    ack_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_ready) |-> (spk_ack[bus_addr] && $onehot(spk_ack)));

    // R2
    ack_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_valid && bus_ready) |-> (spk_ack == '0));

    // R3
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr)));

    // R7
    strobe_fire_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_ready) |=> $onehot(dec_strobe));

    // R7
    strobe_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_valid && bus_ready) |=> (dec_strobe == '0));

    // R9
    idle_chk: assert property (@(posedge clk) disable iff (rst)
        (spk_req == '0) |=> !bus_valid);

    // R10
    back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_ready && ((spk_req & ~spk_ack) != '0)) |=> bus_valid);

endmodule

bind aer_spike_link aer_spike_link_chk #(.N(N)) u_chk (.*);

// File: tb/aer_spike_link_tb.sv
`timescale 1ns/1ps
module aer_spike_link_tb;

    localparam int N  = 8;
    localparam int AW = 3;
    localparam int WAIT_MAX = 2 * N;

    logic          clk = 1'b0;
    logic          rst;
    logic [N-1:0]  spk_req;
    logic [N-1:0]  spk_ack;
    logic [AW-1:0] bus_addr;
    logic          bus_valid;
    logic          bus_ready;
    logic [N-1:0]  dec_strobe;

    int total = 0;
    int bad   = 0;

    logic [N-1:0]  drop_m = '0;
    logic          p_acc  = 1'b0;
    logic          p_stall = 1'b0;
    logic [AW-1:0] p_addr = '0;
    logic [N-1:0]  p_req  = '0;
    logic [N-1:0]  p_ack  = '0;
    int            waits [N];

    always #5 clk = ~clk;

    aer_spike_link #(.N(N)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .spk_req    (spk_req),
        .spk_ack    (spk_ack),
        .bus_addr   (bus_addr),
        .bus_valid  (bus_valid),
        .bus_ready  (bus_ready),
        .dec_strobe (dec_strobe)
    );

    function automatic logic [N-1:0] oh(input logic [AW-1:0] a);
        return N'(1) << a;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: drive inputs at the falling edge, then check the outputs
    task automatic cycle(input int raise_pct, input int ready_pct, input logic [N-1:0] force_m);
        logic [N-1:0] exp_ack;
        logic         acc;
        @(negedge clk);
        spk_req = spk_req & ~drop_m;
        for (int i = 0; i < N; i++) begin
            if (!spk_req[i] && (force_m[i] || (int'($urandom % 100) < raise_pct))) begin
                spk_req[i] = 1'b1;
                waits[i]   = 0;
            end
        end
        bus_ready = (int'($urandom % 100) < ready_pct);
        #1;
        // R1: the address points at a live request
        if (bus_valid) check(spk_req[bus_addr] == 1'b1, "R1", 32'(spk_req), 32'(oh(bus_addr)));
        // R2: acknowledge pattern
        acc     = bus_valid && bus_ready;
        exp_ack = acc ? oh(bus_addr) : '0;
        check(spk_ack == exp_ack, "R2", 32'(spk_ack), 32'(exp_ack));
        // R4: no acknowledge without a held request
        check((spk_ack & ~spk_req) == '0, "R4", 32'(spk_ack), 32'(spk_req));
        // R3: stall holds the event
        if (p_stall) check(bus_valid && bus_addr == p_addr, "R3", {bus_valid, 28'(bus_addr)},
                           {1'b1, 28'(p_addr)});
        // R7: decoded strobe one cycle after acceptance
        check(dec_strobe == (p_acc ? oh(p_addr) : '0), "R7", 32'(dec_strobe),
              32'(p_acc ? oh(p_addr) : '0));
        // R9: idle bus after a cycle with no requests
        if (p_req == '0) check(!bus_valid, "R9", 32'(bus_valid), 0);
        // R10: back-to-back events
        if (p_acc && ((p_req & ~p_ack) != '0)) check(bus_valid, "R10", 32'(bus_valid), 1);
        // R6: bounded wait counted in other neurons' events
        for (int i = 0; i < N; i++) begin
            if (spk_req[i] && acc && !spk_ack[i]) begin
                waits[i]++;
                if (waits[i] > WAIT_MAX) begin
                    check(1'b0, "R6", 32'(waits[i]), WAIT_MAX);
                    waits[i] = 0;
                end
            end
        end
        drop_m  = spk_ack;
        p_acc   = acc;
        p_stall = bus_valid && !bus_ready;
        p_addr  = bus_addr;
        p_req   = spk_req;
        p_ack   = spk_ack;
    endtask

    initial begin
        #2_000_000;
        check(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) waits[i] = 0;
        $urandom(32'd1357);
        rst       = 1'b1;
        spk_req   = '0;
        bus_ready = 1'b0;
        repeat (3) @(negedge clk);
        // R8: outputs quiet in reset
        check(!bus_valid && spk_ack == '0 && dec_strobe == '0, "R8",
              {bus_valid, 8'(spk_ack), 8'(dec_strobe)}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!bus_valid && spk_ack == '0 && dec_strobe == '0, "R8",
              {bus_valid, 8'(spk_ack), 8'(dec_strobe)}, 0);

        // Corner: lone highest and lowest neurons
        cycle(0, 100, N'(1) << (N - 1));
        repeat (4) cycle(0, 100, '0);
        cycle(0, 100, N'(1));
        repeat (4) cycle(0, 100, '0);
        // Corner: everyone fires at once, bus always ready
        cycle(0, 100, '1);
        repeat (2 * N) cycle(0, 100, '0);
        // Corner: everyone fires into a stalled bus, then it opens
        cycle(0, 0, '1);
        repeat (10) cycle(0, 0, '0);
        repeat (3 * N) cycle(0, 100, '0);
        // Steady contention: everyone re-fires as soon as possible
        repeat (400) cycle(100, 100, '0);
        // Random traffic with random back-pressure
        repeat (3000) cycle(30, 60, '0);
        repeat (2000) cycle(70, 35, '0);

        // R5: drain with no new spikes, everything must be acknowledged
        repeat (4 * N) cycle(0, 100, '0);
        @(negedge clk);
        spk_req = spk_req & ~drop_m;
        check(spk_req == '0, "R5", 32'(spk_req), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule